// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing front end of a 512-byte serial EEPROM model. It watches an open-drain two-wire bus through oversampled clock and data inputs. It recognises START and STOP conditions, shifts in a control byte and compares it with its device code and two strapped chip-select inputs. It then runs a write or a read transfer. The non-volatile array and its programming are outside the block. Each received data byte goes out as a one-cycle write strobe with its address. Read data comes back through a synchronous port with one cycle of latency.

The block holds a 9-bit word pointer. On a write, the byte after the control byte sets the low eight pointer bits. The control byte's bit 1 sets the pointer's top bit on every accepted control byte. A repeated START followed by a read control byte therefore gives a random read from that pointer. While the array reports a programming cycle in progress, the block does not acknowledge its control byte. When the master leaves a read byte unacknowledged, the block releases SDA and stays silent until the next START.

The controller is an enumerated machine with nine states:
- ST_IDLE: waits for START.
- ST_CTRL: shifts in the control byte.
- ST_CTRL_ACK: drives the acknowledge for the control byte.
- ST_WADDR and ST_WADDR_ACK: take in and acknowledge the word address.
- ST_WDATA and ST_WDATA_ACK: take in and acknowledge data bytes.
- ST_RDATA: shifts out a read byte.
- ST_RACK: samples the master's acknowledge.

Transitions:
- STOP leads from any state to ST_IDLE, and START leads from any state to ST_CTRL.
- At the SCL fall that ends the eighth bit, ST_CTRL goes to ST_CTRL_ACK on a match, or to ST_IDLE on a mismatch or while busy.
- ST_CTRL_ACK goes to ST_RDATA when R/W=1, or to ST_WADDR when R/W=0.
- ST_WADDR goes to ST_WADDR_ACK, then to ST_WDATA.
- ST_WDATA and ST_WDATA_ACK alternate.
- ST_RDATA goes to ST_RACK, then back to ST_RDATA on an acknowledge or to ST_IDLE on a not-acknowledge.

Top module: `ee2w_slave`

## Requirements
- R1: START (SDA falling while SCL high) restarts control-byte reception from any state, including in the middle of a byte. STOP (SDA rising while SCL high) returns the block to idle with SDA released.
- R2: The control byte is taken MSB first with layout bits[7:4] device code (1010), bits[3:2] compared with chip_sel[1:0] (bit 3 with chip_sel[1]), bit[1] memory address bit 8, bit[0] R/W (1 = read). A matching byte is acknowledged. A mismatching byte is not acknowledged, and later bytes are ignored until the next START.
- R3: While prog_busy is high, a control byte is not acknowledged even when it matches.
- R4: For every byte the block receives, sda_pull is high, and stays unchanged, across the whole high phase of the ninth SCL clock. On the write path it is low again before the next bit's SCL high phase.
- R5: The byte after a write control byte loads the pointer's low eight bits, and the control byte's bit 1 loads pointer bit 8.
- R6: Each received data byte gives exactly one wr_valid pulse carrying the pointer as wr_addr and the byte as wr_data. STOP after a word address alone produces no write.
- R7: After each data byte only the low four pointer bits increment, so writes wrap within a 16-byte page and bits 8..4 stay fixed.
- R8: A read shifts out the byte at the pointer MSB first, and sda_pull changes only while SCL is low.
- R9: A master acknowledge of a read byte increments the full 9-bit pointer (0x0FF to 0x100, 0x1FF to 0x000), and the next byte follows.
- R10: After a master not-acknowledge the block keeps SDA released through any further clocks until a START.
- R11: A repeated START after a word address, followed by a read control byte, reads from the loaded pointer.
- R12: In and just after reset, sda_pull, wr_valid and rd_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 = drive SDA low (open drain), 0 = release |
| chip_sel | input | 2 | Strapped select pins matched against control bits 3:2 |
| prog_busy | input | 1 | Array programming cycle in progress |
| wr_valid | output | 1 | One-cycle strobe for a received data byte |
| wr_addr | output | 9 | Address of the received data byte |
| wr_data | output | 8 | Received data byte |
| rd_en | output | 1 | Synchronous read request to the array |
| rd_addr | output | 9 | Read address (current pointer) |
| rd_data | input | 8 | Array data, valid the cycle after rd_en |

## Verification
Every bus pin change reaches the controller after two synchronizer clocks. The block's registered response, whether an acknowledge, a read bit or a release, appears on sda_pull on the third clock after the SCL fall. The bench therefore samples sda_pull twice inside each SCL high phase, 2 and 6 clocks after the rise, and checks release 6 clocks after the fall. A write strobe appears one clock after the synchronized SCL fall that ends a data byte. A behavioural monitor compares wr_valid, wr_addr and wr_data with a queue of expected writes at every negative clock edge. Read data is checked bit by bit against a reference byte array that the bench updates from its own expected writes.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
    localparam int EE_BYTE_W = 8;
    localparam int EE_ADDR_W = EE_BYTE_W + 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } ee2w_state_e;
endpackage

// File: rtl/ee2w_line_sync.sv
module ee2w_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_ch, sda_ch;
    logic              scl_q, sda_q;

    // synchronizer chains reset to the idle (high) bus level
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ch <= '1;
                    sda_ch <= '1;
                end else begin
                    scl_ch <= scl_raw;
                    sda_ch <= sda_raw;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ch <= '1;
                    sda_ch <= '1;
                end else begin
                    scl_ch <= {scl_ch[STAGES-2:0], scl_raw};
                    sda_ch <= {sda_ch[STAGES-2:0], sda_raw};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_ch[LAST];
            sda_q <= sda_ch[LAST];
        end
    end

    assign scl_lvl   = scl_ch[LAST];
    assign sda_lvl   = sda_ch[LAST];
    assign scl_rise  = scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl & scl_q;
    assign bus_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign bus_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/ee2w_word_ptr.sv
module ee2w_word_ptr #(
    parameter int AW     = 9,
    parameter int PAGE_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_hi,
    input  logic          hi_bit,
    input  logic          load_lo,
    input  logic [AW-2:0] lo_byte,
    input  logic          inc_page,
    input  logic          inc_full,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_hi) begin
            ptr[AW-1] <= hi_bit;
        end else if (load_lo) begin
            ptr[AW-2:0] <= lo_byte;
        end else if (inc_page) begin
            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
        end else if (inc_full) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R7: a page step never disturbs the bits above the page
    a_r7_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        inc_page && !load_hi && !load_lo |=>
            ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W]) &&
            ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + 1'b1);

    // R9: an acknowledged read byte steps the whole pointer
    a_r9_full_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_full && !inc_page && !load_hi && !load_lo |=>
            ptr == $past(ptr) + 1'b1);
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1010,
    parameter int         PAGE_W      = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_pull,
    input  logic [1:0]           chip_sel,
    input  logic                 prog_busy,
    output logic                 wr_valid,
    output logic [EE_ADDR_W-1:0] wr_addr,
    output logic [EE_BYTE_W-1:0] wr_data,
    output logic                 rd_en,
    output logic [EE_ADDR_W-1:0] rd_addr,
    input  logic [EE_BYTE_W-1:0] rd_data
);
    localparam int CNT_W = $clog2(EE_BYTE_W + 1);

    ee2w_state_e state, nxt;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
    logic [CNT_W-1:0]     bit_cnt;
    logic [EE_BYTE_W-1:0] rx_q, tx_q;
    logic                 rd_ld_q, mack_q;
    logic [EE_ADDR_W-1:0] ptr;

    ee2w_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .bus_start(bus_start),
        .bus_stop (bus_stop)
    );

    logic byte_done, ack_done, ctrl_ok;
    logic ctrl_accept, addr_take, data_take, mack_rise, nxt_is_ack;

    assign byte_done  = scl_fall && (bit_cnt == CNT_W'(EE_BYTE_W));
    assign ack_done   = scl_fall && (bit_cnt != '0);
    assign ctrl_ok    = (rx_q[7:4] == DEV_CODE) && (rx_q[3:2] == chip_sel) && !prog_busy;
    assign nxt_is_ack = nxt inside {ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK};

    // next-state logic
    always_comb begin
        nxt = state;
        if (bus_stop) begin
            nxt = ST_IDLE;
        end else if (bus_start) begin
            nxt = ST_CTRL;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_CTRL:      if (byte_done) nxt = ctrl_ok ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK:  if (ack_done)  nxt = rx_q[0] ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (byte_done) nxt = ST_WADDR_ACK;
                ST_WADDR_ACK: if (ack_done)  nxt = ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ack_done)  nxt = ST_WDATA;
                ST_RDATA:     if (byte_done) nxt = ST_RACK;
                ST_RACK:      if (ack_done)  nxt = mack_q ? ST_RDATA : ST_IDLE;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign ctrl_accept = (state == ST_CTRL)  && (nxt == ST_CTRL_ACK);
    assign addr_take   = (state == ST_WADDR) && (nxt == ST_WADDR_ACK);
    assign data_take   = (state == ST_WDATA) && (nxt == ST_WDATA_ACK);
    assign mack_rise   = (state == ST_RACK)  && scl_rise && !sda_lvl;

    ee2w_word_ptr #(.AW(EE_ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_hi (ctrl_accept),
        .hi_bit  (rx_q[1]),
        .load_lo (addr_take),
        .lo_byte (rx_q),
        .inc_page(data_take),
        .inc_full(mack_rise),
        .ptr     (ptr)
    );

    assign rd_addr = ptr;

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_q     <= '0;
            tx_q     <= '1;
            rd_ld_q  <= 1'b0;
            mack_q   <= 1'b0;
            rd_en    <= 1'b0;
            sda_pull <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            if (bus_start || bus_stop || nxt != state) bit_cnt <= '0;
            else if (scl_rise && state != ST_IDLE)     bit_cnt <= bit_cnt + 1'b1;

            if (scl_rise && state inside {ST_CTRL, ST_WADDR, ST_WDATA})
                rx_q <= {rx_q[EE_BYTE_W-2:0], sda_lvl};

            if (scl_rise && state == ST_RACK)
                mack_q <= !sda_lvl;

            rd_en   <= (ctrl_accept && rx_q[0]) || mack_rise;
            rd_ld_q <= rd_en;

            if (rd_ld_q)
                tx_q <= rd_data;
            else if (state == ST_RDATA && nxt == ST_RDATA && scl_fall)
                tx_q <= {tx_q[EE_BYTE_W-2:0], 1'b1};

            if (nxt != state)
                sda_pull <= nxt_is_ack ? 1'b1 : ((nxt == ST_RDATA) ? !tx_q[EE_BYTE_W-1] : 1'b0);
            else if (state == ST_RDATA && scl_fall)
                sda_pull <= !tx_q[EE_BYTE_W-2];

            wr_valid <= data_take;
            if (data_take) begin
                wr_addr <= ptr;
                wr_data <= rx_q;
            end
        end
    end

    // R4: SDA is pulled only in an acknowledge slot or while sending a zero
    a_r4_pull_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> state inside {ST_CTRL_ACK, ST_WADDR_ACK, ST_WDATA_ACK, ST_RDATA});

    // R8: the data output moves only while the synchronized clock is low
    a_r8_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !$past(scl_lvl));

    // R3: a busy array blocks the control acknowledge
    a_r3_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CTRL) && prog_busy |=> state != ST_CTRL_ACK);

    // R6: each write strobe lasts one cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    // R10: a not-acknowledge leaves SDA released
    a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RACK) && (nxt == ST_IDLE) |=> !sda_pull);
endmodule

// File: tb/ee2w_slave_tb_top.sv
module ee2w_slave_tb_top;
    import ee2w_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       m_scl, m_sda;
    logic [1:0] cs;
    logic       busy;
    logic       sda_pull, wr_valid, rd_en;
    logic [8:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;

    wire sda_bus = m_sda & ~sda_pull;

    ee2w_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (sda_bus),
        .sda_pull (sda_pull),
        .chip_sel (cs),
        .prog_busy(busy),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    logic [7:0] arr   [512];
    logic [7:0] ref_m [512];
    int exp_wa[$];
    int exp_wd[$];
    int n_chk = 0;
    int n_fail = 0;

    // array model attached to the block
    always @(posedge clk) begin
        if (rd_en)    rd_data <= arr[rd_addr];
        if (wr_valid) arr[wr_addr] <= wr_data;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the write strobe against the expected queue
    always @(negedge clk) begin
        if (rst_n && wr_valid) begin
            if (exp_wa.size() == 0) begin
                chk("R6 unexpected write strobe", {23'd0, wr_addr}, -1);
            end else begin
                int a, d;
                a = exp_wa.pop_front();
                d = exp_wd.pop_front();
                chk("R6/R7 write address", {23'd0, wr_addr}, a);
                chk("R6 write data", {24'd0, wr_data}, d);
            end
        end
    end

    task automatic expect_write(input int a, input int d);
        exp_wa.push_back(a);
        exp_wd.push_back(d);
        ref_m[a] = d[7:0];
    endtask

    task automatic bus_start();
        if (m_scl) begin
            m_sda = 1'b0; tick(4);
            m_scl = 1'b0; tick(4);
        end else begin
            m_sda = 1'b1; tick(4);
            m_scl = 1'b1; tick(4);
            m_sda = 1'b0; tick(4);
            m_scl = 1'b0; tick(4);
        end
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(4);
        m_sda = 1'b1; tick(8);
    endtask

    task automatic clk_bit(input bit b);
        m_sda = b;    tick(4);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack,
                             input bit rel_chk, input string tag);
        bit p1, p2;
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        m_sda = 1'b1; tick(4);
        m_scl = 1'b1; tick(2);
        p1 = sda_pull; tick(4);
        p2 = sda_pull; tick(2);
        m_scl = 1'b0; tick(6);
        chk({tag, " acknowledge"}, p1, exp_ack);
        chk("R4 acknowledge held through SCL high", p2, p1);
        if (rel_chk) chk("R4 SDA released after acknowledge", sda_pull, 0);
    endtask

    task automatic read_byte(input bit m_ack, input logic [7:0] exp, input string tag);
        logic [7:0] got;
        bit s1, s2;
        int unstable;
        unstable = 0;
        got = '0;
        for (int i = 0; i < 8; i++) begin
            m_scl = 1'b1; tick(2);
            s1 = sda_bus; tick(4);
            s2 = sda_bus; tick(2);
            m_scl = 1'b0; tick(6);
            if (s1 != s2) unstable++;
            got = {got[6:0], s1};
        end
        chk("R8 read bit stable while SCL high", unstable, 0);
        chk(tag, got, exp);
        m_sda = m_ack ? 1'b0 : 1'b1; tick(2);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0; tick(4);
        m_sda = 1'b1; tick(2);
    endtask

    task automatic idle_clocks_released();
        int seen;
        seen = 0;
        for (int i = 0; i < 9; i++) begin
            m_scl = 1'b1; tick(2);
            if (sda_pull) seen++;
            tick(4);
            m_scl = 1'b0; tick(6);
            if (sda_pull) seen++;
        end
        chk("R10 SDA stays released after not-acknowledge", seen, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            arr[i]   = 8'((i * 29 + 7) & 255);
            ref_m[i] = 8'((i * 29 + 7) & 255);
        end
        rst_n = 1'b0;
        m_scl = 1'b1;
        m_sda = 1'b1;
        cs    = 2'b10;
        busy  = 1'b0;
        tick(5);
        // R12 reset state
        chk("R12 sda_pull in reset", sda_pull, 0);
        chk("R12 wr_valid in reset", wr_valid, 0);
        chk("R12 rd_en in reset", rd_en, 0);
        rst_n = 1'b1;
        tick(5);
        chk("R12 sda_pull after reset", sda_pull, 0);
        chk("R12 rd_en after reset", rd_en, 0);

        // R2 R4 R5 R6: byte write to 0x035
        bus_start();
        send_byte(8'hA8, 1'b1, 1'b1, "R2 control write");
        send_byte(8'h35, 1'b1, 1'b1, "R5 word address");
        expect_write(9'h035, 8'h5A);
        send_byte(8'h5A, 1'b1, 1'b1, "R6 data byte");
        bus_stop();

        // R7: page write from 0x17C wraps to 0x170
        bus_start();
        send_byte(8'hAA, 1'b1, 1'b1, "R2 control write high half");
        send_byte(8'h7C, 1'b1, 1'b1, "R5 word address");
        for (int k = 0; k < 6; k++) begin
            int a;
            a = 9'h170 | ((4'hC + k) & 15);
            expect_write(a, (k + 1) * 17);
            send_byte(8'((k + 1) * 17), 1'b1, 1'b1, "R7 page data");
        end
        bus_stop();

        // R11 R8 R9 R10: random read from 0x035
        bus_start();
        send_byte(8'hA8, 1'b1, 1'b1, "R11 control write");
        send_byte(8'h35, 1'b1, 1'b1, "R11 word address");
        bus_start();
        send_byte(8'hA9, 1'b1, 1'b0, "R11 control read");
        read_byte(1'b1, ref_m[9'h035], "R11 random read first byte");
        read_byte(1'b0, ref_m[9'h036], "R9 read next byte");
        idle_clocks_released();
        bus_stop();

        // R9: carry from 0x0FF into 0x100
        bus_start();
        send_byte(8'hA8, 1'b1, 1'b1, "R2 control write");
        send_byte(8'hFF, 1'b1, 1'b1, "R5 word address");
        bus_start();
        send_byte(8'hA9, 1'b1, 1'b0, "R11 control read");
        read_byte(1'b1, ref_m[9'h0FF], "R9 byte at 0x0FF");
        read_byte(1'b0, ref_m[9'h100], "R9 byte at 0x100");
        bus_stop();

        // R9: wrap from 0x1FF to 0x000, R5 high bit from control
        bus_start();
        send_byte(8'hAA, 1'b1, 1'b1, "R5 control write high half");
        send_byte(8'hFF, 1'b1, 1'b1, "R5 word address");
        bus_start();
        send_byte(8'hAB, 1'b1, 1'b0, "R11 control read high half");
        read_byte(1'b1, ref_m[9'h1FF], "R9 byte at 0x1FF");
        read_byte(1'b1, ref_m[9'h000], "R9 wrap to 0x000");
        read_byte(1'b0, ref_m[9'h001], "R9 byte at 0x001");
        bus_stop();

        // R7: page write landed in the array, read back 0x170
        bus_start();
        send_byte(8'hAA, 1'b1, 1'b1, "R2 control write");
        send_byte(8'h70, 1'b1, 1'b1, "R5 word address");
        bus_start();
        send_byte(8'hAB, 1'b1, 1'b0, "R11 control read");
        read_byte(1'b1, ref_m[9'h170], "R7 wrapped byte 0x170");
        read_byte(1'b0, ref_m[9'h171], "R7 wrapped byte 0x171");
        bus_stop();

        // R2: wrong device code, then further bytes ignored
        bus_start();
        send_byte(8'hB8, 1'b0, 1'b1, "R2 wrong device code");
        send_byte(8'h00, 1'b0, 1'b1, "R2 byte after mismatch");
        bus_stop();

        // R2: chip select compare
        cs = 2'b01;
        bus_start();
        send_byte(8'hA8, 1'b0, 1'b1, "R2 chip select mismatch");
        bus_stop();
        bus_start();
        send_byte(8'hA4, 1'b1, 1'b1, "R2 chip select match");
        bus_stop();
        cs = 2'b10;

        // R3: busy array blocks acknowledge
        busy = 1'b1;
        bus_start();
        send_byte(8'hA8, 1'b0, 1'b1, "R3 control while busy");
        send_byte(8'h12, 1'b0, 1'b1, "R3 byte after busy refusal");
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hA8, 1'b1, 1'b1, "R3 control after busy");
        bus_stop();

        // R1 R6: STOP after word address, then current-address read
        bus_start();
        send_byte(8'hA8, 1'b1, 1'b1, "R1 control write");
        send_byte(8'h10, 1'b1, 1'b1, "R1 word address");
        bus_stop();
        chk("R1 SDA released after STOP", sda_pull, 0);
        bus_start();
        send_byte(8'hA9, 1'b1, 1'b0, "R1 control read");
        read_byte(1'b0, ref_m[9'h010], "R1 read after STOP");
        bus_stop();

        // R1: START in the middle of a byte restarts reception
        bus_start();
        clk_bit(1'b1);
        clk_bit(1'b0);
        clk_bit(1'b1);
        bus_start();
        send_byte(8'hA8, 1'b1, 1'b1, "R1 control after mid-byte START");
        bus_stop();

        tick(10);
        chk("R6 all expected writes seen", exp_wa.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule